// File: doc/BRIEF.md
# Flash Write-Status Bit-7 Generator

This block produces the bit-7 value that a parallel NOR flash returns on a read while an internal program or erase job runs. A host accepts a command by pulsing `cmd_done` on the clock cycle that corresponds to the final write-enable rising edge. Status reporting starts only then. From that point the block replaces bit 7 of array reads with a progress bit, but only for reads that hit the job's target. For a program job, the target is the program address. For an erase job, it is any sector chosen for erasure. All other reads pass the array's own bit through.

During a program job, the status bit is the complement of the bit being written, and it becomes the true bit when the job ends. During an erase job, the status bit reads 0 until the erase ends or is suspended, and then it reads 1. A program aimed at a write-protected sector, or an erase whose chosen sectors are all protected, gives a busy window of fixed length and then falls back to plain array reads. An erase can be suspended and resumed, and a program may run while the erase is suspended. Every duration is a cycle-count parameter.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, `busy` and `suspended` are 0 and `rd_bit7` equals `array_bit7` for every address.
- R2: A program command (`cmd_is_erase`=0) accepted while idle raises `busy` from the next cycle for exactly PROG_CYC cycles. During that window a read of the program address returns the inverse of `prog_bit`.
- R3: After a program finishes, a read of the program address returns `prog_bit` until the next accepted command. Reads of other addresses return `array_bit7` before, during and after the program.
- R4: The sector of an address is its top SECT_W bits, and bit i of `erase_sel` and `prot_map` stands for sector i. An accepted erase keeps `busy` high for ERASE_CYC cycles. During that time, reads in chosen sectors return 0 and reads elsewhere return `array_bit7`.
- R5: After an erase finishes, reads in chosen sectors that are not protected return 1. Reads in protected chosen sectors and in unchosen sectors return `array_bit7`.
- R6: A `suspend_req` seen while erasing gives `suspended`=1 and `busy`=0 on the next cycle, and reads in chosen sectors then return 1. After `resume_req`, the erase finishes once it has spent ERASE_CYC cycles in the erasing state, not counting the cycle in which the suspend request was taken.
- R7: A program accepted while suspended behaves as in R2 and R3. `suspended` stays 1 throughout, and the block returns to the suspended state when the program ends.
- R8: A program to a protected sector keeps `busy` high for PROG_ABORT_CYC cycles, with the inverted bit at the program address. Afterwards that address returns `array_bit7`.
- R9: An erase whose chosen sectors are all protected keeps `busy` high for ERASE_ABORT_CYC cycles, with 0 in the chosen sectors. Afterwards those sectors return `array_bit7`.
- R10: The block ignores `cmd_done` while `busy` is high. It also ignores an erase command while suspended and an erase command with no sector chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_done | input | 1 | One-cycle strobe: command sequence completed |
| cmd_is_erase | input | 1 | 1 = erase command, 0 = program command |
| cmd_addr | input | ADDR_W | Program target address |
| prog_bit | input | 1 | Bit 7 of the datum being programmed |
| erase_sel | input | 2**SECT_W | Sectors chosen for erase, one bit per sector |
| prot_map | input | 2**SECT_W | Write-protected sectors, one bit per sector |
| suspend_req | input | 1 | Request to suspend a running erase |
| resume_req | input | 1 | Request to resume a suspended erase |
| rd_addr | input | ADDR_W | Address of the current read |
| array_bit7 | input | 1 | Bit 7 from the storage array at rd_addr |
| rd_bit7 | output | 1 | Bit 7 returned to the host |
| busy | output | 1 | A program, erase or abort window is running |
| suspended | output | 1 | An erase is suspended |

## Verification
A wrong job state or a wrong latched target first shows up on `rd_bit7` at the target address. It appears in the first cycle after the command is accepted, as a bit with the wrong polarity or as a bit passed through from the array. A counter fault shows up only at the end of the window, as a `busy` length that is off by one or more cycles. For that reason the bench counts every busy cycle rather than sampling at a single point. A lost suspend context, such as a cleared erase counter or a cleared sector mask, stays hidden until the resume. It then appears as a wrong remaining busy length and as wrong final reads in the erased sectors.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PABORT,
        ST_ERASE,
        ST_EABORT,
        ST_SUSP
    } fps_state_e;
endpackage

// File: rtl/fps_sector_decode.sv
module fps_sector_decode #(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2,
    localparam int NS = 2 ** SECT_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NS-1:0]     sect_oh
);
    logic [SECT_W-1:0] idx;
    assign idx = addr[ADDR_W-1 -: SECT_W];

    for (genvar i = 0; i < NS; i++) begin : g_sect
        assign sect_oh[i] = (idx == SECT_W'(i));
    end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int SECT_W         = 2,
    parameter int PROG_CYC       = 400,
    parameter int ERASE_CYC      = 20000,
    parameter int PROG_ABORT_CYC = 50,
    parameter int ERASE_ABORT_CYC= 5000,
    localparam int NS    = 2 ** SECT_W,
    localparam int MAXC  = (ERASE_CYC > ERASE_ABORT_CYC) ? ERASE_CYC : ERASE_ABORT_CYC,
    localparam int MAXP  = (PROG_CYC > PROG_ABORT_CYC) ? PROG_CYC : PROG_ABORT_CYC,
    localparam int ECNT_W = $clog2(MAXC + 1),
    localparam int PCNT_W = $clog2(MAXP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              cmd_is_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              prog_bit,
    input  logic [NS-1:0]     cmd_sect_oh,
    input  logic [NS-1:0]     erase_sel,
    input  logic [NS-1:0]     prot_map,
    input  logic              suspend_req,
    input  logic              resume_req,
    output fps_state_e        state_o,
    output logic              susp_ret_o,
    output logic [ADDR_W-1:0] paddr_o,
    output logic              pbit_o,
    output logic [NS-1:0]     sel_o,
    output logic [NS-1:0]     eff_o,
    output logic              done_prog_o,
    output logic              done_ers_o,
    output logic              busy_o,
    output logic              suspended_o
);
    typedef struct packed {
        fps_state_e        st;
        logic              susp_ret;
        logic [ADDR_W-1:0] paddr;
        logic              pbit;
        logic [NS-1:0]     sel;
        logic [NS-1:0]     eff;
        logic              done_prog;
        logic              done_ers;
        logic [PCNT_W-1:0] pcnt;
        logic [ECNT_W-1:0] ecnt;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  can_cmd;
    logic  accept_prog;
    logic  accept_ers;
    logic  prot_hit;
    logic [NS-1:0] eff_new;

    always_comb begin
        can_cmd     = (r_q.st == ST_IDLE) || (r_q.st == ST_SUSP);
        accept_prog = cmd_done && !cmd_is_erase && can_cmd;
        accept_ers  = cmd_done && cmd_is_erase && (r_q.st == ST_IDLE) && (|erase_sel);
        prot_hit    = |(cmd_sect_oh & prot_map);
        eff_new     = erase_sel & ~prot_map;
        r_d         = r_q;

        unique case (r_q.st)
            ST_IDLE, ST_SUSP: begin
                if (accept_prog) begin
                    r_d.paddr     = cmd_addr;
                    r_d.pbit      = prog_bit;
                    r_d.done_prog = 1'b0;
                    r_d.done_ers  = 1'b0;
                    r_d.susp_ret  = (r_q.st == ST_SUSP);
                    if (prot_hit) begin
                        r_d.st   = ST_PABORT;
                        r_d.pcnt = PCNT_W'(PROG_ABORT_CYC - 1);
                    end else begin
                        r_d.st   = ST_PROG;
                        r_d.pcnt = PCNT_W'(PROG_CYC - 1);
                    end
                end else if (accept_ers) begin
                    r_d.sel       = erase_sel;
                    r_d.eff       = eff_new;
                    r_d.done_prog = 1'b0;
                    r_d.done_ers  = 1'b0;
                    if (eff_new == '0) begin
                        r_d.st   = ST_EABORT;
                        r_d.ecnt = ECNT_W'(ERASE_ABORT_CYC - 1);
                    end else begin
                        r_d.st   = ST_ERASE;
                        r_d.ecnt = ECNT_W'(ERASE_CYC - 1);
                    end
                end else if ((r_q.st == ST_SUSP) && resume_req) begin
                    r_d.st = ST_ERASE;
                end
            end
            ST_PROG, ST_PABORT: begin
                if (r_q.pcnt == '0) begin
                    r_d.st        = r_q.susp_ret ? ST_SUSP : ST_IDLE;
                    r_d.susp_ret  = 1'b0;
                    r_d.done_prog = (r_q.st == ST_PROG);
                end else begin
                    r_d.pcnt = r_q.pcnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (suspend_req) begin
                    r_d.st = ST_SUSP;
                end else if (r_q.ecnt == '0) begin
                    r_d.st       = ST_IDLE;
                    r_d.done_ers = 1'b1;
                end else begin
                    r_d.ecnt = r_q.ecnt - 1'b1;
                end
            end
            ST_EABORT: begin
                if (r_q.ecnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.ecnt = r_q.ecnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o     = r_q.st;
    assign susp_ret_o  = r_q.susp_ret;
    assign paddr_o     = r_q.paddr;
    assign pbit_o      = r_q.pbit;
    assign sel_o       = r_q.sel;
    assign eff_o       = r_q.eff;
    assign done_prog_o = r_q.done_prog;
    assign done_ers_o  = r_q.done_ers;
    assign busy_o      = (r_q.st == ST_PROG) || (r_q.st == ST_PABORT) ||
                         (r_q.st == ST_ERASE) || (r_q.st == ST_EABORT);
    assign suspended_o = (r_q.st == ST_SUSP) || r_q.susp_ret;

    a_r2_prog_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !cmd_is_erase && r_q.st == ST_IDLE) |=> busy_o);

    a_r6_suspend_next: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ERASE && suspend_req) |=> (suspended_o && !busy_o));

    a_r7_susp_prog_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG && r_q.susp_ret) |=> suspended_o);

    a_r8_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PABORT) |=> !r_q.done_prog);

    a_r10_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_done) |=> ($stable(r_q.paddr) && $stable(r_q.sel)));
endmodule

// File: rtl/fps_read_mux.sv
module fps_read_mux
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2,
    localparam int NS = 2 ** SECT_W
) (
    input  fps_state_e        state,
    input  logic              susp_ret,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pbit,
    input  logic [NS-1:0]     sel,
    input  logic [NS-1:0]     eff,
    input  logic              done_prog,
    input  logic              done_ers,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NS-1:0]     rd_sect_oh,
    input  logic              array_bit7,
    output logic              rd_bit7
);
    logic pmatch, sel_hit, eff_hit;

    always_comb begin
        pmatch  = (rd_addr == paddr);
        sel_hit = |(rd_sect_oh & sel);
        eff_hit = |(rd_sect_oh & eff);
        rd_bit7 = array_bit7;
        unique case (state)
            ST_PROG, ST_PABORT: begin
                if (pmatch)                  rd_bit7 = ~pbit;
                else if (susp_ret && sel_hit) rd_bit7 = 1'b1;
            end
            ST_ERASE, ST_EABORT: begin
                if (sel_hit)                 rd_bit7 = 1'b0;
                else if (done_prog && pmatch) rd_bit7 = pbit;
            end
            ST_SUSP: begin
                if (done_prog && pmatch)     rd_bit7 = pbit;
                else if (sel_hit)            rd_bit7 = 1'b1;
            end
            default: begin
                if (done_prog && pmatch)     rd_bit7 = pbit;
                else if (done_ers && eff_hit) rd_bit7 = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int SECT_W          = 2,
    parameter int PROG_CYC        = 400,
    parameter int ERASE_CYC       = 20000,
    parameter int PROG_ABORT_CYC  = 50,
    parameter int ERASE_ABORT_CYC = 5000,
    localparam int NS = 2 ** SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              cmd_is_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              prog_bit,
    input  logic [NS-1:0]     erase_sel,
    input  logic [NS-1:0]     prot_map,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              array_bit7,
    output logic              rd_bit7,
    output logic              busy,
    output logic              suspended
);
    logic [NS-1:0]     cmd_oh, rd_oh, sel, eff;
    fps_state_e        st;
    logic              susp_ret, pbit, done_prog, done_ers;
    logic [ADDR_W-1:0] paddr;

    fps_sector_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_cmd_dec (
        .addr(cmd_addr), .sect_oh(cmd_oh));

    fps_sector_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd_dec (
        .addr(rd_addr), .sect_oh(rd_oh));

    fps_ctrl #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .PROG_ABORT_CYC(PROG_ABORT_CYC),
        .ERASE_ABORT_CYC(ERASE_ABORT_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_is_erase(cmd_is_erase),
        .cmd_addr(cmd_addr), .prog_bit(prog_bit), .cmd_sect_oh(cmd_oh),
        .erase_sel(erase_sel), .prot_map(prot_map), .suspend_req(suspend_req),
        .resume_req(resume_req), .state_o(st), .susp_ret_o(susp_ret),
        .paddr_o(paddr), .pbit_o(pbit), .sel_o(sel), .eff_o(eff),
        .done_prog_o(done_prog), .done_ers_o(done_ers), .busy_o(busy),
        .suspended_o(suspended));

    fps_read_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mux (
        .state(st), .susp_ret(susp_ret), .paddr(paddr), .pbit(pbit), .sel(sel),
        .eff(eff), .done_prog(done_prog), .done_ers(done_ers), .rd_addr(rd_addr),
        .rd_sect_oh(rd_oh), .array_bit7(array_bit7), .rd_bit7(rd_bit7));
endmodule

// File: tb/tb_flash_poll_status.sv
module tb_flash_poll_status;
    localparam int CLK_P = 10;
    localparam int PC = 5, EC = 12, PA = 3, EA = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_done = 0, cmd_is_erase = 0, prog_bit = 0;
    logic [7:0] cmd_addr = '0, rd_addr = '0;
    logic [3:0] erase_sel = '0, prot_map = '0;
    logic suspend_req = 0, resume_req = 0, array_bit7 = 0;
    logic rd_bit7, busy, suspended;
    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_poll_status #(.ADDR_W(8), .SECT_W(2), .PROG_CYC(PC), .ERASE_CYC(EC),
        .PROG_ABORT_CYC(PA), .ERASE_ABORT_CYC(EA)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_is_erase(cmd_is_erase),
        .cmd_addr(cmd_addr), .prog_bit(prog_bit), .erase_sel(erase_sel),
        .prot_map(prot_map), .suspend_req(suspend_req), .resume_req(resume_req),
        .rd_addr(rd_addr), .array_bit7(array_bit7), .rd_bit7(rd_bit7),
        .busy(busy), .suspended(suspended));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic arr, input logic exp, input string tag);
        rd_addr = a; array_bit7 = arr; #1;
        chk(rd_bit7 === exp, tag, int'(rd_bit7), int'(exp));
    endtask

    // caller stands at a negedge; ends at the negedge after the accepting edge
    task automatic issue(input logic ers, input logic [7:0] a, input logic b, input logic [3:0] sel);
        cmd_done = 1; cmd_is_erase = ers; cmd_addr = a; prog_bit = b; erase_sel = sel;
        @(negedge clk);
        cmd_done = 0;
    endtask

    task automatic count_busy(input logic [7:0] a, input logic expv, output int n, output int bad);
        n = 0; bad = 0; rd_addr = a; array_bit7 = ~expv;
        while (busy && n < 2000) begin
            #1;
            if (rd_bit7 !== expv) bad++;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(busy === 0, "R1 busy after reset", int'(busy), 0);
        chk(suspended === 0, "R1 suspended after reset", int'(suspended), 0);
        rd_chk(8'h15, 1, 1, "R1 array pass 1");
        rd_chk(8'hC5, 0, 0, "R1 array pass 0");
    endtask

    task automatic t_program;
        int n, bad;
        prot_map = 4'b0000;
        issue(0, 8'h15, 0, 4'b0000);
        rd_chk(8'h33, 1, 1, "R3 other addr during program");
        count_busy(8'h15, 1, n, bad);
        chk(n == PC, "R2 program busy length", n, PC);
        chk(bad == 0, "R2 inverted bit during program", bad, 0);
        rd_chk(8'h15, 1, 0, "R3 true bit after program");
        rd_chk(8'h16, 1, 1, "R3 other addr after program");
        issue(0, 8'h22, 1, 4'b0000);
        count_busy(8'h22, 0, n, bad);
        chk(n == PC && bad == 0, "R2 program of 1", bad, 0);
        rd_chk(8'h22, 0, 1, "R3 true 1 after program");
        rd_chk(8'h15, 1, 1, "R3 old target cleared by new command");
    endtask

    task automatic t_erase;
        int n, bad;
        prot_map = 4'b0100;
        issue(1, 8'h00, 0, 4'b0110);
        rd_chk(8'hC5, 1, 1, "R4 unchosen sector during erase");
        rd_chk(8'h85, 1, 0, "R4 protected chosen sector reads 0");
        count_busy(8'h45, 0, n, bad);
        chk(n == EC, "R4 erase busy length", n, EC);
        chk(bad == 0, "R4 zero in chosen sector", bad, 0);
        rd_chk(8'h45, 0, 1, "R5 erased sector reads 1");
        rd_chk(8'h85, 0, 0, "R5 protected sector follows array");
        rd_chk(8'h05, 0, 0, "R5 unchosen sector follows array");
    endtask

    task automatic t_suspend;
        int n, bad, b1;
        prot_map = 4'b0000;
        issue(1, 8'h00, 0, 4'b1000);
        b1 = 0;
        repeat (3) begin b1++; @(negedge clk); end
        suspend_req = 1; b1++;
        @(negedge clk);
        suspend_req = 0;
        chk(suspended === 1 && busy === 0, "R6 suspend within one cycle", int'(suspended), 1);
        rd_chk(8'hC0, 0, 1, "R6 chosen sector reads 1 when suspended");
        @(negedge clk);
        issue(0, 8'h10, 0, 4'b0000);
        chk(suspended === 1 && busy === 1, "R7 program during suspend", int'(busy), 1);
        count_busy(8'h10, 1, n, bad);
        chk(n == PC && bad == 0, "R7 suspended program status", n, PC);
        chk(suspended === 1 && busy === 0, "R7 back to suspended", int'(suspended), 1);
        rd_chk(8'h10, 1, 0, "R7 true bit after suspended program");
        issue(1, 8'h00, 0, 4'b0001);
        chk(busy === 0 && suspended === 1, "R10 erase ignored while suspended", int'(busy), 0);
        resume_req = 1;
        @(negedge clk);
        resume_req = 0;
        count_busy(8'hC5, 0, n, bad);
        chk(b1 + n == EC + 1, "R6 erase length across suspend", b1 + n, EC + 1);
        chk(bad == 0, "R6 zero after resume", bad, 0);
        rd_chk(8'hC5, 0, 1, "R6 erase done after resume");
    endtask

    task automatic t_aborts;
        int n, bad;
        prot_map = 4'b0001;
        issue(0, 8'h05, 1, 4'b0000);
        count_busy(8'h05, 0, n, bad);
        chk(n == PA && bad == 0, "R8 protected program window", n, PA);
        rd_chk(8'h05, 0, 0, "R8 array after abort 0");
        rd_chk(8'h05, 1, 1, "R8 array after abort 1");
        prot_map = 4'b0011;
        issue(1, 8'h00, 0, 4'b0011);
        count_busy(8'h45, 0, n, bad);
        chk(n == EA && bad == 0, "R9 protected erase window", n, EA);
        rd_chk(8'h45, 0, 0, "R9 array after erase abort");
    endtask

    task automatic t_ignored;
        int n, bad;
        prot_map = 4'b0000;
        issue(0, 8'h30, 1, 4'b0000);
        cmd_done = 1; cmd_is_erase = 1; erase_sel = 4'b0001;
        @(negedge clk);
        cmd_done = 0;
        count_busy(8'h30, 0, n, bad);
        chk(n == PC - 1, "R10 command while busy ignored", n, PC - 1);
        rd_chk(8'h30, 0, 1, "R10 program target kept");
        issue(1, 8'h00, 0, 4'b0000);
        chk(busy === 0 && suspended === 0, "R10 empty erase ignored", int'(busy), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_suspend();
        t_aborts();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule